// File: doc/BRIEF.md
# Cache-block operation decode and check

This block sits beside an instruction decoder. It recognises the three cache-block maintenance instructions (clean, flush, invalidate) and the cache-block zero instruction in a 32-bit instruction word. For each one it aligns the base address held in the source register down to the cache-block boundary.

It then decides whether the operation is enabled at the current privilege level. The decision uses three per-level enable vectors: machine, hypervisor and supervisor. If the operation is enabled, the block resolves access permission from the load and store permission results. A translation stub supplies those results for the aligned address. The block reports one exception code that a trap unit can take directly.

The result is registered. It appears one clock after the request, together with a valid strobe. It carries the operation kind, the aligned address, the enable and permission verdicts, the exception code and the faulting address.

Top module: `cbo_decode_check`

## Requirements
- R1: A word is a cache-block instruction only if all of these hold: bits [6:0]=0001111, [14:12]=010, [11:7]=00000 and [31:25]=0000000. In that case bits [24:20] select the operation: 00000 is invalidate (op=1), 00001 is clean (op=2), 00010 is flush (op=3) and 00100 is zero (op=4). The `is_cbo` output is high for these words.
- R2: Any other word gives `is_cbo`=0, op=0, `exc_cause`=0, `perm_ok`=0, `enable_ok`=0 and `aligned_addr`=0. This covers an unlisted [24:20] value, a nonzero rd field and a different opcode.
- R3: `aligned_addr` is `rs1_val` with the bits below the block size cleared. Maintenance operations use parameter MBLK and zero uses parameter ZBLK; both default to 64 bytes.
- R4: Enable rule. Below machine mode (priv 3), a clear machine enable bit raises illegal instruction (code 1). Otherwise, when virtualized, a clear hypervisor bit raises virtual instruction (code 2). Otherwise, in user mode (priv 0), a clear supervisor bit raises code 2 if virtualized and code 1 if not. Machine mode is always enabled.
- R5: The enable vectors use bit 0 for zero, bit 1 for clean and flush together, and bit 2 for invalidate.
- R6: When an enabled maintenance operation has load permission, `perm_ok`=1 and `exc_cause`=0.
- R7: When an enabled maintenance operation lacks load permission but has store permission, `perm_ok`=1 and `exc_cause`=0.
- R8: When an enabled operation is refused access, the code is store page fault (3) outside virtualization and store guest-page fault (4) when virtualized. `fault_addr` then equals `aligned_addr`. For every other code `fault_addr` is 0.
- R9: With parameter MGMT_EN=0, the three maintenance encodings report their op with `exc_cause`=1.
- R10: Outputs are registered. `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R11: After synchronous reset, `out_valid`=0, op=0 and `exc_cause`=0.
- R12: Zero checks store permission only. Without store permission it faults as in R8, even when load permission is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| rs1_val | input | AW | Base address from source register |
| priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| virt | input | 1 | Virtualization mode active |
| m_en | input | 3 | Machine-level enables |
| h_en | input | 3 | Hypervisor-level enables |
| s_en | input | 3 | Supervisor-level enables |
| load_ok | input | 1 | Load permitted on the aligned block |
| store_ok | input | 1 | Store permitted on the aligned block |
| out_valid | output | 1 | Result strobe |
| is_cbo | output | 1 | Word was a cache-block instruction |
| op | output | 3 | Operation code |
| aligned_addr | output | AW | Block-aligned address |
| enable_ok | output | 1 | Operation enabled at this level |
| perm_ok | output | 1 | Access permitted |
| exc_cause | output | 4 | Exception code (0 none) |
| fault_addr | output | AW | Address reported with a page fault |

## Verification
The assertions check several properties on every cycle:
- the one-cycle relation between `in_valid` and `out_valid`;
- the cleared low bits of maintenance addresses;
- that a non-virtualized request never yields a guest fault and a virtualized request never yields a plain page fault;
- that an exception implies a recognised instruction and that a granted permission never carries a code.

The full enable priority across privilege levels needs the bench's scenarios, as do the separate enable bits per operation, the load-then-store fallback, the store-only check for zero and the parameter-disabled maintenance set.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_INVAL = 3'd1,
    OP_CLEAN = 3'd2,
    OP_FLUSH = 3'd3,
    OP_ZERO  = 3'd4
  } cbo_op_e;

  typedef enum logic [3:0] {
    EXC_NONE  = 4'd0,
    EXC_ILL   = 4'd1,
    EXC_VIRT  = 4'd2,
    EXC_SPF   = 4'd3,
    EXC_GSPF  = 4'd4
  } cbo_exc_e;

  localparam int EN_ZERO_BIT = 0;
  localparam int EN_CF_BIT   = 1;
  localparam int EN_INV_BIT  = 2;
  localparam int EN_W        = 3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;
  localparam logic [2:0] F3_CBO       = 3'b010;
endpackage

// File: rtl/cbo_field_decode.sv
module cbo_field_decode
  import cbo_pkg::*;
#(
  parameter bit MGMT_EN = 1'b1,
  parameter bit ZERO_EN = 1'b1
) (
  input  logic [31:0] instr,
  output logic        is_cbo,
  output cbo_op_e     op,
  output logic        unsupported
);
  logic frame_ok;

  assign frame_ok = (instr[6:0] == OPC_MISC_MEM) && (instr[14:12] == F3_CBO) &&
                    (instr[11:7] == 5'd0) && (instr[31:25] == 7'd0);

  always_comb begin
    is_cbo      = 1'b0;
    op          = OP_NONE;
    unsupported = 1'b0;
    if (frame_ok) begin
      unique case (instr[24:20])
        5'b00000: begin is_cbo = 1'b1; op = OP_INVAL; unsupported = !MGMT_EN; end
        5'b00001: begin is_cbo = 1'b1; op = OP_CLEAN; unsupported = !MGMT_EN; end
        5'b00010: begin is_cbo = 1'b1; op = OP_FLUSH; unsupported = !MGMT_EN; end
        5'b00100: begin is_cbo = 1'b1; op = OP_ZERO;  unsupported = !ZERO_EN; end
        default:  begin is_cbo = 1'b0; op = OP_NONE; end
      endcase
    end
  end
endmodule

// File: rtl/cbo_env_gate.sv
module cbo_env_gate
  import cbo_pkg::*;
(
  input  logic            is_cbo,
  input  cbo_op_e         op,
  input  logic            unsupported,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic [EN_W-1:0] m_en,
  input  logic [EN_W-1:0] h_en,
  input  logic [EN_W-1:0] s_en,
  output cbo_exc_e        cause
);
  logic [EN_W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (op)
      OP_INVAL: sel[EN_INV_BIT]  = 1'b1;
      OP_ZERO:  sel[EN_ZERO_BIT] = 1'b1;
      default:  sel[EN_CF_BIT]   = 1'b1;
    endcase
  end

  always_comb begin
    cause = EXC_NONE;
    if (unsupported) begin
      cause = EXC_ILL;
    end else if (is_cbo && priv != PRIV_M) begin
      if ((m_en & sel) == '0)
        cause = EXC_ILL;
      else if (virt && (h_en & sel) == '0)
        cause = EXC_VIRT;
      else if (priv == PRIV_U && (s_en & sel) == '0)
        cause = virt ? EXC_VIRT : EXC_ILL;
    end
  end
endmodule

// File: rtl/cbo_access_check.sv
module cbo_access_check
  import cbo_pkg::*;
(
  input  cbo_op_e  op,
  input  logic     load_ok,
  input  logic     store_ok,
  input  logic     virt,
  output logic     granted,
  output cbo_exc_e cause
);
  always_comb begin
    if (op == OP_ZERO)
      granted = store_ok;
    else if (load_ok)
      granted = 1'b1;
    else
      granted = store_ok;
    if (granted)
      cause = EXC_NONE;
    else
      cause = virt ? EXC_GSPF : EXC_SPF;
  end
endmodule

// File: rtl/cbo_decode_check.sv
module cbo_decode_check
  import cbo_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MBLK    = 64,
  parameter int ZBLK    = 64,
  parameter bit MGMT_EN = 1'b1,
  parameter bit ZERO_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [AW-1:0] rs1_val,
  input  logic [1:0]    priv,
  input  logic          virt,
  input  logic [2:0]    m_en,
  input  logic [2:0]    h_en,
  input  logic [2:0]    s_en,
  input  logic          load_ok,
  input  logic          store_ok,
  output logic          out_valid,
  output logic          is_cbo,
  output logic [2:0]    op,
  output logic [AW-1:0] aligned_addr,
  output logic          enable_ok,
  output logic          perm_ok,
  output logic [3:0]    exc_cause,
  output logic [AW-1:0] fault_addr
);
  localparam logic [AW-1:0] MMASK = AW'(MBLK - 1);
  localparam logic [AW-1:0] ZMASK = AW'(ZBLK - 1);

  logic          d_cbo, d_unsup;
  cbo_op_e       d_op;
  cbo_exc_e      env_cause, acc_cause, fin_cause;
  logic          acc_granted, d_en, d_perm;
  logic [AW-1:0] d_aligned;

  cbo_field_decode #(.MGMT_EN(MGMT_EN), .ZERO_EN(ZERO_EN)) u_dec (
    .instr(instr), .is_cbo(d_cbo), .op(d_op), .unsupported(d_unsup)
  );

  cbo_env_gate u_gate (
    .is_cbo(d_cbo), .op(d_op), .unsupported(d_unsup), .priv(priv), .virt(virt),
    .m_en(m_en), .h_en(h_en), .s_en(s_en), .cause(env_cause)
  );

  cbo_access_check u_acc (
    .op(d_op), .load_ok(load_ok), .store_ok(store_ok), .virt(virt),
    .granted(acc_granted), .cause(acc_cause)
  );

  always_comb begin
    if (!d_cbo)
      d_aligned = '0;
    else if (d_op == OP_ZERO)
      d_aligned = rs1_val & ~ZMASK;
    else
      d_aligned = rs1_val & ~MMASK;
    d_en   = d_cbo && (env_cause == EXC_NONE);
    d_perm = d_en && acc_granted;
    if (!d_cbo)
      fin_cause = EXC_NONE;
    else if (env_cause != EXC_NONE)
      fin_cause = env_cause;
    else
      fin_cause = acc_cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      is_cbo       <= 1'b0;
      op           <= OP_NONE;
      aligned_addr <= '0;
      enable_ok    <= 1'b0;
      perm_ok      <= 1'b0;
      exc_cause    <= EXC_NONE;
      fault_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_cbo       <= d_cbo;
        op           <= d_op;
        aligned_addr <= d_aligned;
        enable_ok    <= d_en;
        perm_ok      <= d_perm;
        exc_cause    <= fin_cause;
        fault_addr   <= (fin_cause == EXC_SPF || fin_cause == EXC_GSPF) ? d_aligned : '0;
      end
    end
  end
endmodule

// File: rtl/cbo_decode_check_sva.sv
module cbo_decode_check_sva #(
  parameter int AW   = 32,
  parameter int MBLK = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          virt,
  input logic          out_valid,
  input logic          is_cbo,
  input logic [2:0]    op,
  input logic [AW-1:0] aligned_addr,
  input logic          perm_ok,
  input logic [3:0]    exc_cause
);
  localparam int MLG = $clog2(MBLK);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_mgmt_aligned: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op != 3'd4) |-> aligned_addr[MLG-1:0] == '0);
  a_r8_no_guest_fault_native: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !virt) |=> exc_cause != 4'd4);
  a_r8_no_plain_fault_virt: assert property (@(posedge clk) disable iff (rst)
    (in_valid && virt) |=> exc_cause != 4'd3);
  a_r2_exc_needs_cbo: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_cause != 4'd0) |-> is_cbo);
  a_r6_grant_no_exc: assert property (@(posedge clk) disable iff (rst)
    (out_valid && perm_ok) |-> exc_cause == 4'd0);
endmodule

bind cbo_decode_check cbo_decode_check_sva #(.AW(AW), .MBLK(MBLK)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .virt(virt), .out_valid(out_valid),
  .is_cbo(is_cbo), .op(op), .aligned_addr(aligned_addr), .perm_ok(perm_ok),
  .exc_cause(exc_cause)
);

// File: tb/sim_cbo_decode_check.sv
module sim_cbo_decode_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs1_val = '0;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic [2:0]  m_en = '0, h_en = '0, s_en = '0;
  logic        load_ok = 1'b0, store_ok = 1'b0;

  logic        out_valid, is_cbo, enable_ok, perm_ok;
  logic [2:0]  op;
  logic [31:0] aligned_addr, fault_addr;
  logic [3:0]  exc_cause;
  logic        v1_valid, v1_cbo, v1_en, v1_perm;
  logic [2:0]  v1_op;
  logic [31:0] v1_al, v1_fa;
  logic [3:0]  v1_exc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cbo_decode_check u0 (
    .clk, .rst, .in_valid, .instr, .rs1_val, .priv, .virt, .m_en, .h_en, .s_en,
    .load_ok, .store_ok, .out_valid, .is_cbo, .op, .aligned_addr, .enable_ok,
    .perm_ok, .exc_cause, .fault_addr
  );

  cbo_decode_check #(.MGMT_EN(1'b0)) u1 (
    .clk, .rst, .in_valid, .instr, .rs1_val, .priv, .virt, .m_en, .h_en, .s_en,
    .load_ok, .store_ok, .out_valid(v1_valid), .is_cbo(v1_cbo), .op(v1_op),
    .aligned_addr(v1_al), .enable_ok(v1_en), .perm_ok(v1_perm), .exc_cause(v1_exc),
    .fault_addr(v1_fa)
  );

  // Instruction words with rs1 field 10: base 0x0005200F plus selector << 20
  localparam logic [31:0] I_INV  = 32'h0005200F;
  localparam logic [31:0] I_CLN  = 32'h0015200F;
  localparam logic [31:0] I_FLS  = 32'h0025200F;
  localparam logic [31:0] I_ZER  = 32'h0045200F;
  localparam logic [31:0] I_BADS = 32'h0035200F;
  localparam logic [31:0] I_RDNZ = 32'h0015208F;
  localparam logic [31:0] I_OPC  = 32'h00152013;
  localparam logic [31:0] A0 = 32'h12345678;
  localparam logic [31:0] A0AL = 32'h12345640;

  // {instr, addr, priv, virt, m, h, s, ld, st, exp_op, exp_cause, exp_perm, exp_aligned}
  localparam int NV = 17;
  localparam logic [117:0] VEC [NV] = '{
    {I_CLN, A0, 2'd3, 1'b0, 3'b000, 3'b000, 3'b000, 1'b1, 1'b0, 3'd2, 4'd0, 1'b1, A0AL}, // R4 machine bypass, R6
    {I_FLS, A0, 2'd1, 1'b0, 3'b111, 3'b000, 3'b000, 1'b0, 1'b1, 3'd3, 4'd0, 1'b1, A0AL}, // R7 store fallback
    {I_INV, A0, 2'd1, 1'b0, 3'b111, 3'b000, 3'b000, 1'b0, 1'b0, 3'd1, 4'd3, 1'b0, A0AL}, // R8 native fault
    {I_INV, A0, 2'd1, 1'b1, 3'b111, 3'b111, 3'b000, 1'b0, 1'b0, 3'd1, 4'd4, 1'b0, A0AL}, // R8 guest fault
    {I_CLN, A0, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1, 3'd2, 4'd1, 1'b0, A0AL}, // R5 bit1 clear
    {I_FLS, A0, 2'd1, 1'b0, 3'b101, 3'b111, 3'b111, 1'b1, 1'b1, 3'd3, 4'd1, 1'b0, A0AL}, // R5 flush shares bit1
    {I_INV, A0, 2'd1, 1'b0, 3'b011, 3'b111, 3'b111, 1'b1, 1'b1, 3'd1, 4'd1, 1'b0, A0AL}, // R5 bit2 clear
    {I_INV, A0, 2'd1, 1'b0, 3'b101, 3'b000, 3'b000, 1'b1, 1'b0, 3'd1, 4'd0, 1'b1, A0AL}, // R5 inval ignores bit1
    {I_CLN, A0, 2'd1, 1'b1, 3'b111, 3'b101, 3'b111, 1'b1, 1'b1, 3'd2, 4'd2, 1'b0, A0AL}, // R4 hyp clear
    {I_CLN, A0, 2'd0, 1'b0, 3'b111, 3'b111, 3'b101, 1'b1, 1'b1, 3'd2, 4'd1, 1'b0, A0AL}, // R4 user native
    {I_CLN, A0, 2'd0, 1'b1, 3'b111, 3'b111, 3'b101, 1'b1, 1'b1, 3'd2, 4'd2, 1'b0, A0AL}, // R4 user virt
    {I_ZER, A0, 2'd1, 1'b0, 3'b111, 3'b000, 3'b000, 1'b1, 1'b0, 3'd4, 4'd3, 1'b0, A0AL}, // R12 load ignored
    {I_ZER, A0, 2'd1, 1'b0, 3'b111, 3'b000, 3'b000, 1'b0, 1'b1, 3'd4, 4'd0, 1'b1, A0AL}, // R12 store grants
    {I_BADS, A0, 2'd3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1, 3'd0, 4'd0, 1'b0, 32'h0}, // R2 bad selector
    {I_RDNZ, A0, 2'd3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1, 3'd0, 4'd0, 1'b0, 32'h0}, // R2 rd nonzero
    {I_OPC, A0, 2'd3, 1'b0, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1, 3'd0, 4'd0, 1'b0, 32'h0},  // R2 other opcode
    {I_CLN, 32'hFFFFFFFF, 2'd3, 1'b0, 3'b0, 3'b0, 3'b0, 1'b1, 1'b0, 3'd2, 4'd0, 1'b1, 32'hFFFFFFC0} // R3 top
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [117:0] v);
    @(negedge clk);
    instr = v[117:86]; rs1_val = v[85:54]; priv = v[53:52]; virt = v[51];
    m_en = v[50:48]; h_en = v[47:45]; s_en = v[44:42];
    load_ok = v[41]; store_ok = v[40]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 op", {29'd0, op}, 32'd0);
    chk("R11 cause", {28'd0, exc_cause}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 idle", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [117:0] v;
      logic [31:0] efa;
      v = VEC[i];
      issue(v);
      efa = (v[36:33] == 4'd3 || v[36:33] == 4'd4) ? v[31:0] : 32'd0;
      chk("R10 valid", {31'd0, out_valid}, 32'd1);
      chk("R1 op", {29'd0, op}, {29'd0, v[39:37]});
      chk("R1 is_cbo", {31'd0, is_cbo}, {31'd0, v[39:37] != 3'd0});
      chk("R3 aligned", aligned_addr, v[31:0]);
      chk("R4 cause", {28'd0, exc_cause}, {28'd0, v[36:33]});
      chk("R6 perm", {31'd0, perm_ok}, {31'd0, v[32]});
      chk("R8 fault_addr", fault_addr, efa);
      @(negedge clk);
      chk("R10 drop", {31'd0, out_valid}, 32'd0);
    end

    // R9 maintenance disabled by parameter on u1; zero still allowed
    issue(VEC[0]);
    chk("R9 op", {29'd0, v1_op}, 32'd2);
    chk("R9 cause", {28'd0, v1_exc}, 32'd1);
    issue(VEC[12]);
    chk("R9 zero kept", {28'd0, v1_exc}, 32'd0);

    // R10 back-to-back requests then hold of outputs
    @(negedge clk);
    instr = I_INV; rs1_val = A0; priv = 2'd1; virt = 1'b0; m_en = 3'b111;
    load_ok = 1'b0; store_ok = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 b2b first", {28'd0, exc_cause}, 32'd3);
    virt = 1'b1; h_en = 3'b111;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 b2b second", {28'd0, exc_cause}, 32'd4);
    @(negedge clk);
    chk("R10 hold", {28'd0, exc_cause}, 32'd4);

    // R11 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R11 rerst", {28'd0, exc_cause}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule